// File: doc/BRIEF.md
# Write-Streaming No-Allocate Detector

This block sits beside a cache controller and watches the cache-line writes that miss and would normally allocate. It tracks runs of line writes whose line addresses step up by exactly one line. Once a run grows long enough it tells the controller to stop allocating the current line in the first-level cache, and, after a longer run, in the second-level cache too. Each level has its own 2-bit threshold code. The second-level code also has a value that switches the whole detector off.

One run counter feeds two threshold decoders. The run logic is a two-state machine. `ST_IDLE` means no run is being tracked. `ST_RUN` means a run is open, and the counter and the last line address are valid. Its transitions are:
- *start*: `ST_IDLE` to `ST_RUN` on a write-allocate line, count 1.
- *extend*: `ST_RUN` to `ST_RUN` when the address is the previous one plus one, count incremented and saturating.
- *restart*: `ST_RUN` to `ST_RUN` on any other address, count 1.
- *clear*: any state to `ST_IDLE` on a threshold write with no line, or to `ST_RUN` with count 1 if a line arrives in the same cycle.

The decision for a line is registered and appears one cycle after the line event.

Top module: `wsd_stream_detect`

## Requirements
- R1: After reset both codes are 00 and all outputs are 0. With no threshold write, a run of consecutive lines is suppressed at the first level from line 4 and at the second level from line 12.
- R2: `dec_valid` is 1 in exactly the cycle after each `line_wr_valid` cycle and 0 otherwise. The two decision outputs for an event are valid in that same cycle.
- R3: A write-allocate line whose `line_addr` equals the previous write-allocate line's address plus 1 extends the run. Any other address starts a new run whose count is 1, and the current line is included in the count.
- R4: With second-level code 00, 01 or 10, `no_alloc_l2` is 1 for lines whose run count is at least 12, 128 or 512 respectively.
- R5: With second-level code 11 both `no_alloc_l2` and `no_alloc_l1` are 0 for every line.
- R6: With first-level code 00, 01 or 10 (and second-level code not 11), `no_alloc_l1` is 1 for lines whose run count is at least 4, 64 or 128 respectively.
- R7: First-level code 11 disables the first-level threshold. `no_alloc_l1` is then 1 only when `no_alloc_l2` is 1.
- R8: Whenever `no_alloc_l2` is 1, `no_alloc_l1` is also 1.
- R9: A line event with `line_wr_alloc` = 0 yields both decisions 0. It neither extends nor breaks the run, and its address is not remembered.
- R10: The run count saturates above 512, so a run longer than 512 lines stays suppressed and never wraps back.
- R11: A `cfg_wr` pulse loads both codes and clears the run. The next write-allocate line counts as 1, even if it is consecutive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_wr_valid | input | 1 | A line write event this cycle |
| line_wr_alloc | input | 1 | The event is a write-allocate line |
| line_addr | input | ADDR_W | Line-granular address of the event |
| cfg_wr | input | 1 | Load the threshold codes and clear the run |
| cfg_l1_code | input | 2 | First-level threshold code to load |
| cfg_l2_code | input | 2 | Second-level threshold code to load |
| dec_valid | output | 1 | Decision outputs belong to the previous cycle's event |
| no_alloc_l1 | output | 1 | Do not allocate the line in the first-level cache |
| no_alloc_l2 | output | 1 | Do not allocate the line in the second-level cache |

## Verification
The assertions assume that reset is held low until the inputs are driven to known values. They also assume that `line_wr_alloc`, `line_addr` and the code inputs matter only in cycles where their strobe is high. The bench drives every input on the falling clock edge and keeps `line_wr_valid` and `cfg_wr` low throughout reset. It drives the code inputs only together with a `cfg_wr` pulse, so the registered codes that the checker sees change only at a clearing write.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int CODE_W   = 2;
    localparam logic [CODE_W-1:0] CODE_OFF = 2'b11;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wsd_thresh_lut.sv
module wsd_thresh_lut
    import wsd_pkg::*;
#(
    parameter int T0    = 4,
    parameter int T1    = 64,
    parameter int T2    = 128,
    parameter int CNT_W = 10
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  count,
    output logic              hit
);

    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(T0);
        unique case (code)
            2'b00:   limit = CNT_W'(T0);
            2'b01:   limit = CNT_W'(T1);
            2'b10:   limit = CNT_W'(T2);
            default: limit = CNT_W'(T0);
        endcase
        hit = (code != CODE_OFF) && (count >= limit);
    end

endmodule

// File: rtl/wsd_run_fsm.sv
module wsd_run_fsm
    import wsd_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int CNT_W  = 10,
    parameter int SAT    = 513
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clear,
    output logic [CNT_W-1:0]  count_now
);

    run_state_e        state_q, state_d, base_st;
    logic [CNT_W-1:0]  cnt_q, cnt_new;
    logic [ADDR_W-1:0] last_q;
    logic              step_ok;

    assign step_ok = (addr == last_q + ADDR_W'(1));

    always_comb begin
        base_st = clear ? ST_IDLE : state_q;
        state_d = base_st;
        cnt_new = cnt_q;
        unique case (base_st)
            ST_IDLE: begin
                if (evt) begin
                    state_d = ST_RUN;
                    cnt_new = CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (evt) begin
                    if (step_ok)
                        cnt_new = (cnt_q >= CNT_W'(SAT)) ? CNT_W'(SAT) : cnt_q + CNT_W'(1);
                    else
                        cnt_new = CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_new;
            if (evt)
                last_q <= addr;
        end
    end

    assign count_now = cnt_new;

endmodule

// File: rtl/wsd_stream_detect.sv
module wsd_stream_detect
    import wsd_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int L1_T0  = 4,
    parameter int L1_T1  = 64,
    parameter int L1_T2  = 128,
    parameter int L2_T0  = 12,
    parameter int L2_T1  = 128,
    parameter int L2_T2  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_wr_valid,
    input  logic              line_wr_alloc,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_l1_code,
    input  logic [1:0]        cfg_l2_code,
    output logic              dec_valid,
    output logic              no_alloc_l1,
    output logic              no_alloc_l2
);

    localparam int SAT   = max3(max3(L1_T0, L1_T1, L1_T2), max3(L2_T0, L2_T1, L2_T2), 1) + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [CODE_W-1:0] l1_code_q, l2_code_q, l1_code_eff, l2_code_eff;
    logic [CNT_W-1:0]  count_now;
    logic              alloc_evt, l1_hit, l2_hit;

    assign alloc_evt   = line_wr_valid && line_wr_alloc;
    assign l1_code_eff = cfg_wr ? cfg_l1_code : l1_code_q;
    assign l2_code_eff = cfg_wr ? cfg_l2_code : l2_code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_code_q <= '0;
            l2_code_q <= '0;
        end else if (cfg_wr) begin
            l1_code_q <= cfg_l1_code;
            l2_code_q <= cfg_l2_code;
        end
    end

    wsd_run_fsm #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SAT    (SAT)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (alloc_evt),
        .addr      (line_addr),
        .clear     (cfg_wr),
        .count_now (count_now)
    );

    wsd_thresh_lut #(.T0(L1_T0), .T1(L1_T1), .T2(L1_T2), .CNT_W(CNT_W)) u_l1_lut (
        .code  (l1_code_eff),
        .count (count_now),
        .hit   (l1_hit)
    );

    wsd_thresh_lut #(.T0(L2_T0), .T1(L2_T1), .T2(L2_T2), .CNT_W(CNT_W)) u_l2_lut (
        .code  (l2_code_eff),
        .count (count_now),
        .hit   (l2_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            no_alloc_l1 <= 1'b0;
            no_alloc_l2 <= 1'b0;
        end else begin
            dec_valid   <= line_wr_valid;
            no_alloc_l2 <= alloc_evt && l2_hit;
            no_alloc_l1 <= alloc_evt && (l2_code_eff != CODE_OFF) && (l2_hit || l1_hit);
        end
    end

endmodule

// File: rtl/wsd_stream_detect_chk.sv
module wsd_stream_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_wr_valid,
    input logic       line_wr_alloc,
    input logic       cfg_wr,
    input logic [1:0] l2_code_q,
    input logic       dec_valid,
    input logic       no_alloc_l1,
    input logic       no_alloc_l2
);

    p_dec_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_valid |=> dec_valid);

    p_no_spurious_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wr_valid |=> !dec_valid);

    p_l2_implies_l1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_alloc_l2 |-> no_alloc_l1);

    p_nonalloc_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr_valid && !line_wr_alloc) |=> (!no_alloc_l1 && !no_alloc_l2));

    p_l2_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_code_q == 2'b11) |-> (!no_alloc_l1 && !no_alloc_l2));

    p_cfg_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!no_alloc_l1 && !no_alloc_l2));

endmodule

bind wsd_stream_detect wsd_stream_detect_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_wr_valid (line_wr_valid),
    .line_wr_alloc (line_wr_alloc),
    .cfg_wr        (cfg_wr),
    .l2_code_q     (l2_code_q),
    .dec_valid     (dec_valid),
    .no_alloc_l1   (no_alloc_l1),
    .no_alloc_l2   (no_alloc_l2)
);

// File: tb/test_wsd_stream_detect.sv
module test_wsd_stream_detect;

    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_wr_valid = 1'b0;
    logic          line_wr_alloc = 1'b0;
    logic [AW-1:0] line_addr = '0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_l1_code = 2'b00;
    logic [1:0]    cfg_l2_code = 2'b00;
    logic          dec_valid, no_alloc_l1, no_alloc_l2;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    wsd_stream_detect #(.ADDR_W(AW)) i_wsd_stream_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_wr_valid (line_wr_valid),
        .line_wr_alloc (line_wr_alloc),
        .line_addr     (line_addr),
        .cfg_wr        (cfg_wr),
        .cfg_l1_code   (cfg_l1_code),
        .cfg_l2_code   (cfg_l2_code),
        .dec_valid     (dec_valid),
        .no_alloc_l1   (no_alloc_l1),
        .no_alloc_l2   (no_alloc_l2)
    );

    // Table: codes, run length, first line suppressed at L1 / L2 (0 = never)
    localparam int NV = 8;
    localparam int V_L1 [NV] = '{0, 1, 1, 2, 3, 0, 2, 3};
    localparam int V_L2 [NV] = '{0, 0, 1, 2, 1, 3, 3, 3};
    localparam int V_LEN[NV] = '{20, 70, 140, 600, 140, 30, 20, 20};
    localparam int V_E1 [NV] = '{4, 12, 64, 128, 128, 0, 0, 0};
    localparam int V_E2 [NV] = '{12, 12, 128, 512, 128, 0, 0, 0};

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] c1, input logic [1:0] c2);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_l1_code = c1; cfg_l2_code = c2;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send_line(input logic [AW-1:0] a, input logic alloc,
                             output logic o1, output logic o2, output logic ov);
        @(negedge clk);
        line_wr_valid = 1'b1; line_wr_alloc = alloc; line_addr = a;
        @(negedge clk);
        line_wr_valid = 1'b0; line_wr_alloc = 1'b0;
        o1 = no_alloc_l1; o2 = no_alloc_l2; ov = dec_valid;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic o1, o2, ov;
        int   exp1, exp2;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!dec_valid && !no_alloc_l1 && !no_alloc_l2, "R1 outputs in reset",
              {dec_valid, no_alloc_l1, no_alloc_l2}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dec_valid && !no_alloc_l1 && !no_alloc_l2, "R1 outputs after reset",
              {dec_valid, no_alloc_l1, no_alloc_l2}, 0);

        // R1: default codes give thresholds 4 and 12
        for (int i = 1; i <= 12; i++) begin
            send_line(AW'(100 + i), 1'b1, o1, o2, ov);
            if (i == 3 || i == 4 || i == 11 || i == 12) begin
                exp1 = (i >= 4) ? 1 : 0;
                exp2 = (i >= 12) ? 1 : 0;
                check(o1 == exp1[0] && o2 == exp2[0], "R1 default thresholds",
                      {o1, o2}, {exp1[0], exp2[0]});
            end
        end

        // R2: decision strobe timing
        send_line(AW'(5000), 1'b1, o1, o2, ov);
        check(ov == 1'b1, "R2 dec_valid one cycle after event", ov, 1);
        @(negedge clk);
        check(dec_valid == 1'b0, "R2 dec_valid drops without event", dec_valid, 0);

        // R4 R5 R6 R7 R8 R10: threshold table
        for (int k = 0; k < NV; k++) begin
            cfg(V_L1[k][1:0], V_L2[k][1:0]);
            for (int i = 1; i <= V_LEN[k]; i++) begin
                send_line(AW'(32'h10000 * (k + 1) + i), 1'b1, o1, o2, ov);
                exp1 = (V_E1[k] != 0 && i >= V_E1[k]) ? 1 : 0;
                exp2 = (V_E2[k] != 0 && i >= V_E2[k]) ? 1 : 0;
                if (o1 != exp1[0] || o2 != exp2[0] || !ov)
                    $display("  vector %0d line %0d", k, i);
                check(o1 == exp1[0] && o2 == exp2[0] && ov,
                      "R4 R5 R6 R7 R8 R10 table line",
                      {ov, o1, o2}, {1'b1, exp1[0], exp2[0]});
            end
        end

        // R3: non-consecutive address restarts the run
        cfg(2'b00, 2'b01);
        for (int i = 0; i < 6; i++) send_line(AW'(700 + i), 1'b1, o1, o2, ov);
        check(o1 == 1'b1, "R3 sixth consecutive line suppressed", o1, 1);
        send_line(AW'(900), 1'b1, o1, o2, ov);
        check(o1 == 1'b0, "R3 jump restarts count at 1", o1, 0);
        send_line(AW'(901), 1'b1, o1, o2, ov);
        send_line(AW'(902), 1'b1, o1, o2, ov);
        check(o1 == 1'b0, "R3 third line of new run", o1, 0);
        send_line(AW'(903), 1'b1, o1, o2, ov);
        check(o1 == 1'b1, "R3 fourth line of new run", o1, 1);
        send_line(AW'(903), 1'b1, o1, o2, ov);
        check(o1 == 1'b0, "R3 repeated address restarts", o1, 0);

        // R9: non-allocating event is transparent
        cfg(2'b00, 2'b01);
        for (int i = 0; i < 3; i++) send_line(AW'(2000 + i), 1'b1, o1, o2, ov);
        send_line(AW'(7777), 1'b0, o1, o2, ov);
        check(ov && !o1 && !o2, "R9 non-alloc decision", {ov, o1, o2}, 4);
        send_line(AW'(2003), 1'b1, o1, o2, ov);
        check(o1 == 1'b1, "R9 run continues past non-alloc", o1, 1);

        // R11: threshold write clears the run
        for (int i = 4; i < 8; i++) send_line(AW'(2000 + i), 1'b1, o1, o2, ov);
        check(o1 == 1'b1, "R11 run suppressed before write", o1, 1);
        cfg(2'b00, 2'b01);
        send_line(AW'(2008), 1'b1, o1, o2, ov);
        check(o1 == 1'b0, "R11 consecutive line after write counts 1", o1, 0);
        for (int i = 9; i < 12; i++) send_line(AW'(2000 + i), 1'b1, o1, o2, ov);
        check(o1 == 1'b1, "R11 fourth line after write", o1, 1);

        summary();
    end

endmodule